// File: doc/BRIEF.md
# Victim Buffer for a Write-Back Cache

This block sits between a write-back cache and the memory below it. When the cache evicts a dirty line it hands the line here and carries on at once. The block keeps the line, with its line address, and writes it to memory later over a valid/ready port. It takes the oldest held line first and keeps the presented line steady until memory accepts it. The cache stalls an eviction only while every slot is occupied.

While a line waits here, the cache can still get it back. On a miss the cache sends a lookup with the line address. One cycle later the block answers with hit or miss and, on a hit, the 128-bit line. A hit gives the line back to the cache, which holds it dirty again, so the buffered copy leaves the writeback queue. There is one exception: the line may already be on the memory port. In that case the write still finishes as normal, and the entry only stops answering lookups.

Top module: `victim_buffer`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the buffer is empty: `evict_ready` is 1, `mem_valid` is 0 and `resp_valid` is 0.
- R2: `evict_ready` is 1 whenever fewer than 4 entries are occupied. An eviction is taken in a cycle where both `evict_valid` and `evict_ready` are 1.
- R3: With all 4 entries occupied, `evict_ready` is 0. An eviction offered in such a cycle is not stored and never reaches the memory port.
- R4: `mem_valid` is 1 exactly when at least one line waits for writeback. `mem_addr` and `mem_data` then carry the oldest waiting line, so lines reach memory in the order they were accepted.
- R5: While `mem_valid` is 1 and `mem_ready` is 0, the next cycle shows `mem_valid` still 1 with the same `mem_addr` and `mem_data`.
- R6: A lookup in cycle t (`lookup_valid` = 1) gives `resp_valid` = 1 in cycle t+1. `resp_hit` tells whether a held, unclaimed line had the address `lookup_addr`. On a hit `resp_data` is that line, on a miss it is all zeros. `resp_valid` is 0 after a cycle without a lookup.
- R7: A hit on a line that is not on the memory port removes it: it is never written to memory, and a later lookup of the same address misses.
- R8: A hit on the line currently at the memory port still returns the line. That write then completes exactly once, and later lookups of the address miss.
- R9: Every accepted line reaches memory exactly once, except the lines removed as in R7.
- R10: A lookup searches only lines held before its cycle. A line evicted in the same cycle as a lookup of its address does not produce a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| evict_valid | input | 1 | Cache offers an evicted dirty line |
| evict_ready | output | 1 | A free slot exists; the offered line is taken |
| evict_addr | input | 32 | Line address of the evicted line |
| evict_data | input | 128 | Contents of the evicted line |
| lookup_valid | input | 1 | Cache searches the buffer after a miss |
| lookup_addr | input | 32 | Line address being searched |
| resp_valid | output | 1 | Answer to the lookup of the previous cycle |
| resp_hit | output | 1 | The searched line was held |
| resp_data | output | 128 | Returned line on a hit, zero on a miss |
| mem_valid | output | 1 | A writeback is offered to memory |
| mem_ready | input | 1 | Memory accepts the offered writeback |
| mem_addr | output | 32 | Line address of the offered writeback |
| mem_data | output | 128 | Line contents of the offered writeback |

## Verification
The assertions watch the cycle-level rules on every cycle:
- the empty state after reset;
- the one-cycle answer to every lookup, with zero data on a miss;
- a steady memory port while it is stalled;
- a non-empty queue right after an accepted eviction;
- a pending writeback whenever evictions are refused.

Only the bench's scenarios can show the rest, because that needs memory of which lines went in and what came out. This covers writeback order, whether a returned line is still written, exactly-once delivery over long random runs, and the same-cycle evict-and-lookup case.

// File: rtl/vb_pkg.sv
package vb_pkg;

    localparam int unsigned VB_DEPTH  = 4;
    localparam int unsigned VB_ADDR_W = 32;
    localparam int unsigned VB_LINE_W = 128;

    // Per-slot state: occupied, and already handed back to the cache
    // while its writeback is in flight.
    typedef struct packed {
        logic valid;
        logic claimed;
    } vb_flag_t;

    // Number of set bits in a small mask (zero-extended by the caller).
    function automatic int unsigned vb_count_set(input logic [31:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 32; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/vb_match.sv
module vb_match
    import vb_pkg::*;
#(
    parameter int unsigned DEPTH  = VB_DEPTH,
    parameter int unsigned ADDR_W = VB_ADDR_W,
    parameter int unsigned LINE_W = VB_LINE_W
) (
    input  logic                          lookup_valid,
    input  logic [ADDR_W-1:0]             lookup_addr,
    input  vb_flag_t [DEPTH-1:0]          flags,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  addrs,
    input  logic [DEPTH-1:0][LINE_W-1:0]  lines,
    output logic [DEPTH-1:0]              take,
    output logic                          hit,
    output logic [LINE_W-1:0]             hit_line
);

    logic [DEPTH-1:0] cand;

    // Candidate slots: held, not yet returned, same line address.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign cand[g] = lookup_valid && flags[g].valid && !flags[g].claimed
                         && (addrs[g] == lookup_addr);
    end

    // Lowest matching slot wins, giving a one-hot take vector.
    always_comb begin
        take     = '0;
        hit_line = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (cand[j] && (take == '0)) begin
                take[j]  = 1'b1;
                hit_line = lines[j];
            end
        end
    end

    assign hit = |cand;

endmodule

// File: rtl/vb_store.sv
module vb_store
    import vb_pkg::*;
#(
    parameter int unsigned DEPTH  = VB_DEPTH,
    parameter int unsigned ADDR_W = VB_ADDR_W,
    parameter int unsigned LINE_W = VB_LINE_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          push,
    input  logic [ADDR_W-1:0]             push_addr,
    input  logic [LINE_W-1:0]             push_data,
    input  logic                          pop,
    input  logic [DEPTH-1:0]              take,
    output vb_flag_t [DEPTH-1:0]          flags,
    output logic [DEPTH-1:0][ADDR_W-1:0]  addrs,
    output logic [DEPTH-1:0][LINE_W-1:0]  lines
);

    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    vb_flag_t [DEPTH-1:0]          nxt_flags;
    logic [DEPTH-1:0][ADDR_W-1:0]  nxt_addrs;
    logic [DEPTH-1:0][LINE_W-1:0]  nxt_lines;
    logic                          drop;
    int unsigned                   dst;

    // Slots stay packed oldest-first from slot 0. Removed slots are
    // squeezed out, and a new line lands just above the survivors.
    // Slot 0 is the memory port and is removed only by a pop; a hit on
    // it while stalled just marks it claimed.
    always_comb begin
        nxt_flags = '0;
        nxt_addrs = addrs;
        nxt_lines = lines;
        dst       = 0;
        drop      = 1'b0;
        for (int j = 0; j < DEPTH; j++) begin
            drop = (j == 0) ? pop : take[IDX_W'(j)];
            if (flags[IDX_W'(j)].valid && !drop) begin
                nxt_flags[IDX_W'(dst)].valid   = 1'b1;
                nxt_flags[IDX_W'(dst)].claimed = flags[IDX_W'(j)].claimed
                                                 || take[IDX_W'(j)];
                nxt_addrs[IDX_W'(dst)]         = addrs[IDX_W'(j)];
                nxt_lines[IDX_W'(dst)]         = lines[IDX_W'(j)];
                dst                            = dst + 1;
            end
        end
        if (push && (dst < DEPTH)) begin
            nxt_flags[IDX_W'(dst)].valid   = 1'b1;
            nxt_flags[IDX_W'(dst)].claimed = 1'b0;
            nxt_addrs[IDX_W'(dst)]         = push_addr;
            nxt_lines[IDX_W'(dst)]         = push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= nxt_flags;
        end
        addrs <= nxt_addrs;
        lines <= nxt_lines;
    end

endmodule

// File: rtl/vb_resp.sv
module vb_resp
    import vb_pkg::*;
#(
    parameter int unsigned LINE_W = VB_LINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lookup_valid,
    input  logic              hit,
    input  logic [LINE_W-1:0] hit_line,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [LINE_W-1:0] resp_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_data  <= '0;
        end else begin
            resp_valid <= lookup_valid;
            resp_hit   <= lookup_valid && hit;
            resp_data  <= (lookup_valid && hit) ? hit_line : '0;
        end
    end

endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
    import vb_pkg::*;
#(
    parameter int unsigned DEPTH  = VB_DEPTH,
    parameter int unsigned ADDR_W = VB_ADDR_W,
    parameter int unsigned LINE_W = VB_LINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evict_valid,
    output logic              evict_ready,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic [LINE_W-1:0] evict_data,
    input  logic              lookup_valid,
    input  logic [ADDR_W-1:0] lookup_addr,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [LINE_W-1:0] resp_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_data
);

    vb_flag_t [DEPTH-1:0]          flags;
    logic [DEPTH-1:0][ADDR_W-1:0]  addrs;
    logic [DEPTH-1:0][LINE_W-1:0]  lines;
    logic [DEPTH-1:0]              take;
    logic                          hit;
    logic [LINE_W-1:0]             hit_line;
    logic                          push;
    logic                          pop;

    // Packed storage: the top slot is occupied only when all are.
    assign evict_ready = !flags[DEPTH-1].valid;
    assign push        = evict_valid && evict_ready;
    assign mem_valid   = flags[0].valid;
    assign mem_addr    = addrs[0];
    assign mem_data    = lines[0];
    assign pop         = mem_valid && mem_ready;

    vb_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_match (
        .lookup_valid (lookup_valid),
        .lookup_addr  (lookup_addr),
        .flags        (flags),
        .addrs        (addrs),
        .lines        (lines),
        .take         (take),
        .hit          (hit),
        .hit_line     (hit_line)
    );

    vb_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_addr (evict_addr),
        .push_data (evict_data),
        .pop       (pop),
        .take      (take),
        .flags     (flags),
        .addrs     (addrs),
        .lines     (lines)
    );

    vb_resp #(.LINE_W(LINE_W)) u_resp (
        .clk          (clk),
        .rst          (rst),
        .lookup_valid (lookup_valid),
        .hit          (hit),
        .hit_line     (hit_line),
        .resp_valid   (resp_valid),
        .resp_hit     (resp_hit),
        .resp_data    (resp_data)
    );

endmodule

// File: rtl/vb_checker.sv
module vb_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LINE_W = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              evict_valid,
    input logic              evict_ready,
    input logic              lookup_valid,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic [LINE_W-1:0] resp_data,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LINE_W-1:0] mem_data
);

    // R1
    reset_empty_chk: assert property (@(posedge clk)
        rst |=> (evict_ready && !mem_valid && !resp_valid));

    // R2
    accept_fills_chk: assert property (@(posedge clk) disable iff (rst)
        (evict_valid && evict_ready) |=> mem_valid);

    // R3
    refuse_has_work_chk: assert property (@(posedge clk) disable iff (rst)
        !evict_ready |-> mem_valid);

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R6
    resp_follows_chk: assert property (@(posedge clk) disable iff (rst)
        lookup_valid |=> resp_valid);

    // R6
    resp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !lookup_valid |=> !resp_valid);

    // R6
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit) |-> (resp_data == '0));

endmodule

bind victim_buffer vb_checker #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_vb_chk (
    .clk          (clk),
    .rst          (rst),
    .evict_valid  (evict_valid),
    .evict_ready  (evict_ready),
    .lookup_valid (lookup_valid),
    .resp_valid   (resp_valid),
    .resp_hit     (resp_hit),
    .resp_data    (resp_data),
    .mem_valid    (mem_valid),
    .mem_ready    (mem_ready),
    .mem_addr     (mem_addr),
    .mem_data     (mem_data)
);

// File: tb/test_victim_buffer.sv
`timescale 1ns/1ps
module test_victim_buffer;

    localparam int DEPTH = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         evict_valid = 1'b0;
    logic         evict_ready;
    logic [31:0]  evict_addr = '0;
    logic [127:0] evict_data = '0;
    logic         lookup_valid = 1'b0;
    logic [31:0]  lookup_addr = '0;
    logic         resp_valid;
    logic         resp_hit;
    logic [127:0] resp_data;
    logic         mem_valid;
    logic         mem_ready = 1'b0;
    logic [31:0]  mem_addr;
    logic [127:0] mem_data;

    always #2 clk = ~clk;

    victim_buffer i_victim_buffer (
        .clk(clk), .rst(rst),
        .evict_valid(evict_valid), .evict_ready(evict_ready),
        .evict_addr(evict_addr), .evict_data(evict_data),
        .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data)
    );

    typedef struct {
        logic [31:0]  a;
        logic [127:0] d;
        bit           cl;
    } ent_t;

    ent_t         q[$];
    int           checks = 0;
    int           failures = 0;
    bit           done = 0;
    bit           exp_rv = 0;
    bit           exp_hit = 0;
    logic [127:0] exp_data = '0;
    string        exp_tag = "R6";
    bit           prev_stall = 0;
    logic [31:0]  prev_addr = '0;
    int           accepted = 0;
    int           written = 0;
    int           dropped = 0;
    logic [31:0]  next_a = 32'h100;

    function automatic logic [127:0] rnd_line();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Lowest held, unclaimed slot with this address, or -1.
    function automatic int find(input logic [31:0] a);
        for (int i = 0; i < q.size(); i++)
            if (!q[i].cl && q[i].a == a) return i;
        return -1;
    endfunction

    task automatic step(input bit ev, input logic [31:0] ea, input logic [127:0] ed,
                        input bit lk, input logic [31:0] la, input bit mr,
                        input string tag);
        int h;
        bit pop;
        bit acc;
        @(negedge clk);
        // port checks against the model
        chk(evict_ready == (q.size() < DEPTH), (q.size() < DEPTH) ? "R2" : "R3",
            128'(evict_ready), 128'(q.size() < DEPTH));
        chk(mem_valid == (q.size() > 0), "R4", 128'(mem_valid), 128'(q.size() > 0));
        if (q.size() > 0) begin
            chk(mem_addr == q[0].a, "R4", 128'(mem_addr), 128'(q[0].a));
            chk(mem_data == q[0].d, "R4", mem_data, q[0].d);
        end
        if (prev_stall)
            chk(mem_valid && mem_addr == prev_addr, "R5", 128'(mem_addr), 128'(prev_addr));
        chk(resp_valid == exp_rv, exp_tag, 128'(resp_valid), 128'(exp_rv));
        if (exp_rv) begin
            chk(resp_hit == exp_hit, exp_tag, 128'(resp_hit), 128'(exp_hit));
            chk(resp_data == exp_data, exp_tag, resp_data, exp_data);
        end
        // drive
        evict_valid  = ev;
        evict_addr   = ea;
        evict_data   = ed;
        lookup_valid = lk;
        lookup_addr  = la;
        mem_ready    = mr;
        // model update
        acc        = ev && (q.size() < DEPTH);
        pop        = (q.size() > 0) && mr;
        prev_stall = (q.size() > 0) && !mr;
        prev_addr  = (q.size() > 0) ? q[0].a : '0;
        h          = lk ? find(la) : -1;
        exp_rv     = lk;
        exp_hit    = (h >= 0);
        exp_data   = (h >= 0) ? q[h].d : '0;
        exp_tag    = tag;
        if (h > 0) begin
            q.delete(h);
            dropped++;
        end else if (h == 0 && !pop) begin
            q[0].cl = 1;
        end
        if (pop) begin
            q.delete(0);
            written++;
        end
        if (acc) begin
            q.push_back('{a: ea, d: ed, cl: 0});
            accepted++;
        end
        @(posedge clk);
    endtask

    task automatic drain();
        for (int i = 0; i < 20; i++) step(0, '0, '0, 0, '0, 1, "R6");
    endtask

    initial begin
        logic [31:0] a [5];
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: values during reset
        chk(evict_ready == 1'b1, "R1", 128'(evict_ready), 128'(1));
        chk(mem_valid == 1'b0, "R1", 128'(mem_valid), 128'(0));
        chk(resp_valid == 1'b0, "R1", 128'(resp_valid), 128'(0));
        rst = 1'b0;
        // R1 (first cycle after reset) checked in this step
        step(0, '0, '0, 0, '0, 0, "R1");

        // Fill with memory stalled, then offer a fifth line (R3)
        for (int i = 0; i < 5; i++) a[i] = 32'h1000 + 32'(i);
        for (int i = 0; i < 4; i++) step(1, a[i], rnd_line(), 0, '0, 0, "R6");
        step(1, a[4], rnd_line(), 0, '0, 0, "R6");
        // R7: hit a non-inflight slot, then look it up again
        step(0, '0, '0, 1, a[2], 0, "R7");
        step(0, '0, '0, 1, a[2], 0, "R7");
        // R8: hit the line on the memory port while stalled
        step(0, '0, '0, 1, a[0], 0, "R8");
        step(0, '0, '0, 1, a[0], 0, "R8");
        // R10: evict and look up the same new address together
        step(1, 32'h2000, rnd_line(), 1, 32'h2000, 0, "R10");
        step(0, '0, '0, 1, 32'h2000, 1, "R6");
        drain();

        // Constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            bit ev;
            bit lk;
            bit mr;
            logic [31:0] la;
            ev = ($urandom % 100) < 45;
            lk = ($urandom % 100) < 35;
            mr = ($urandom % 100) < 30;
            if (q.size() > 0 && ($urandom % 2) == 0)
                la = q[$urandom % q.size()].a;
            else
                la = 32'hF000_0000 | ($urandom % 64);
            step(ev, next_a, rnd_line(), lk, la, mr, "R6");
            if (ev) next_a++;
        end
        drain();
        // R9: every accepted line written once unless removed by a hit
        chk(written == accepted - dropped, "R9", 128'(written), 128'(accepted - dropped));
        chk(q.size() == 0 && !mem_valid, "R9", 128'(mem_valid), 128'(0));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule